// File: doc/BRIEF.md
# Snooping Cache-Line Coherence Controller

This block keeps the coherence state of every line held by one private cache that sits on a shared snooping bus. It is driven from two sides. The local core sends read, write and evict requests. The bus delivers the read and read-for-ownership transactions that other caches issue. For each cycle the block decides which bus transaction the cache must issue. It also decides whether to raise the shared-line response, whether to supply data cache-to-cache, whether to flush a dirty line to memory, and whether an eviction needs a memory write-back. Data storage, bus arbitration and main memory lie outside the block. Only the state and control decisions are made here.

A parameter selects one of two policies for a dirty line that another cache reads:
- **Four-state policy (MESI):** the dirty line is flushed to memory and becomes Shared.
- **Five-state policy (MOESI):** the dirty line becomes Owned. It keeps serving further readers cache-to-cache, and the memory write waits until the line is evicted.

Each line is tracked as a single unit. Writes by two caches to different words of the same line therefore still invalidate each other's copy.

The state array is indexed by line number. One core request and one snooped transaction are accepted per cycle. The block reports the present state of the line the core addresses, so the data path can tell a hit from a miss and a clean line from a dirty one.

Top module: `coh_line_ctrl`

## Requirements

State codes are I=0, S=1, E=2, O=3, M=4. Core operation codes are none=0, read=1, write=2, evict=3. Bus and snoop operation codes are none=0, BusRd=1, BusRdX=2.

All outputs are combinational within the request cycle. State changes take effect at the next clock edge.

- R1: A core read of a line in I issues BusRd (bus_req=1). If `shared_in` is low, the line becomes E. After reset every line reads as I, and a read of a valid line issues no bus request.
- R2: A core read of a line in I while `shared_in` is high issues BusRd and leaves the line in S. A snooped BusRd hitting a line in E or S raises `shared_out`. An E line drops to S and an S line stays S.
- R3: A core write to a line in E moves it to M and issues no bus request.
- R4: A core write to a line in S or O issues BusRdX (bus_req=2), and the line becomes M.
- R5: A core write to a line in I issues BusRdX, and the line becomes M.
- R6: With the four-state policy, a snooped BusRd hitting an M line raises `shared_out`, `supply_out` and `flush_out`, and the line becomes S.
- R7: With the five-state policy, a snooped BusRd hitting an M line raises `shared_out` and `supply_out` with no flush, and the line becomes O.
- R8: A snooped BusRd hitting an O line raises `shared_out` and `supply_out` with no flush, and the line stays O.
- R9: Evicting an M or O line raises `wb_out` and leaves the line in I. Evicting an E or S line leaves it in I without `wb_out`.
- R10: A core write to a line already in M issues no bus request, and the line stays M.
- R11: A snooped transaction hitting a line in I raises none of `shared_out`, `supply_out`, `flush_out`, and the line stays I.
- R12: A snooped BusRdX hitting a valid line moves it to I. `supply_out` is raised only when the line was M or O.
- R13: When a snoop and a core request name the same line in one cycle, the snoop is applied first. The core request is then judged against the state the snoop left. `cur_state` still reports the state from before both.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset; all lines become I |
| core_op | input | 2 | Core request: 0 none, 1 read, 2 write, 3 evict |
| core_idx | input | IW | Line index of the core request |
| shared_in | input | 1 | Wired shared response from other caches during this cache's BusRd |
| snp_op | input | 2 | Snooped bus transaction: 0 none, 1 BusRd, 2 BusRdX |
| snp_idx | input | IW | Line index of the snooped transaction |
| bus_req | output | 2 | Bus transaction to issue: 0 none, 1 BusRd, 2 BusRdX |
| shared_out | output | 1 | This cache holds the snooped line |
| supply_out | output | 1 | This cache drives the snooped line's data on the bus |
| flush_out | output | 1 | The supplied data is also written to memory |
| wb_out | output | 1 | The evicted line must be written back to memory |
| cur_state | output | 3 | State of line `core_idx` before this cycle's updates |

## Verification

Two instances run side by side, one per policy, and receive the same stimulus. Any difference between them isolates the dirty-line read behaviour of R6 and R7.

A directed walk steps single lines through every transition:
- from I into E or S, depending on the shared response;
- silent and non-silent upgrades;
- repeated reads of an Owned line;
- evictions from each state.

Random traffic is confined to four line indices so that snoops and core requests collide on the same line often. These collisions separate correct snoop-first ordering from a design that looks up the stale state. Random levels on `shared_in` tell apart installs into E and into S.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [2:0] {
        ST_I = 3'd0,
        ST_S = 3'd1,
        ST_E = 3'd2,
        ST_O = 3'd3,
        ST_M = 3'd4
    } line_st_t;

    typedef enum logic [1:0] {
        CO_NONE = 2'd0,
        CO_RD   = 2'd1,
        CO_WR   = 2'd2,
        CO_EV   = 2'd3
    } core_op_t;

    typedef enum logic [1:0] {
        BX_NONE = 2'd0,
        BX_RD   = 2'd1,
        BX_RDX  = 2'd2,
        BX_RSV  = 2'd3
    } bus_op_t;

    typedef struct packed {
        logic shared;
        logic supply;
        logic flush;
    } snp_resp_t;

endpackage

// File: rtl/coh_snoop_fsm.sv
module coh_snoop_fsm
    import coh_pkg::*;
#(
    parameter bit MOESI = 1'b1
) (
    input  line_st_t  cur,
    input  bus_op_t   op,
    output line_st_t  nxt,
    output snp_resp_t resp
);
    always_comb begin
        nxt  = cur;
        resp = '0;
        unique case (op)
            BX_RD: begin
                unique case (cur)
                    ST_E: begin
                        nxt         = ST_S;
                        resp.shared = 1'b1;
                    end
                    ST_S: resp.shared = 1'b1;
                    ST_M: begin
                        resp.shared = 1'b1;
                        resp.supply = 1'b1;
                        if (MOESI) begin
                            nxt = ST_O;
                        end else begin
                            nxt        = ST_S;
                            resp.flush = 1'b1;
                        end
                    end
                    ST_O: begin
                        resp.shared = 1'b1;
                        resp.supply = 1'b1;
                    end
                    default: nxt = cur;
                endcase
            end
            BX_RDX: begin
                if (cur != ST_I) begin
                    nxt         = ST_I;
                    resp.supply = (cur == ST_M) || (cur == ST_O);
                end
            end
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/coh_core_fsm.sv
module coh_core_fsm
    import coh_pkg::*;
(
    input  line_st_t cur,
    input  core_op_t op,
    input  logic     shared_in,
    output line_st_t nxt,
    output bus_op_t  req,
    output logic     wb
);
    always_comb begin
        nxt = cur;
        req = BX_NONE;
        wb  = 1'b0;
        unique case (op)
            CO_RD: begin
                if (cur == ST_I) begin
                    req = BX_RD;
                    nxt = shared_in ? ST_S : ST_E;
                end
            end
            CO_WR: begin
                if (cur == ST_I || cur == ST_S || cur == ST_O) begin
                    req = BX_RDX;
                end
                nxt = ST_M;
            end
            CO_EV: begin
                wb  = (cur == ST_M) || (cur == ST_O);
                nxt = ST_I;
            end
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
    import coh_pkg::*;
#(
    parameter int LINES = 16,
    parameter bit MOESI = 1'b1,
    localparam int IW   = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    core_op,
    input  logic [IW-1:0] core_idx,
    input  logic          shared_in,
    input  logic [1:0]    snp_op,
    input  logic [IW-1:0] snp_idx,
    output logic [1:0]    bus_req,
    output logic          shared_out,
    output logic          supply_out,
    output logic          flush_out,
    output logic          wb_out,
    output logic [2:0]    cur_state
);
    line_st_t  arr_q [LINES];
    line_st_t  arr_d [LINES];

    core_op_t  c_op;
    bus_op_t   s_op;
    line_st_t  snp_cur, snp_nxt, core_cur, core_nxt;
    snp_resp_t snp_resp;
    bus_op_t   core_req;
    logic      core_wb;
    logic      snp_act, same_line;

    assign c_op      = core_op_t'(core_op);
    assign s_op      = bus_op_t'(snp_op);
    assign snp_act   = (s_op == BX_RD) || (s_op == BX_RDX);
    assign same_line = snp_act && (snp_idx == core_idx);
    assign snp_cur   = arr_q[snp_idx];
    // R13: the core sees the state the snoop leaves behind
    assign core_cur  = same_line ? snp_nxt : arr_q[core_idx];

    coh_snoop_fsm #(.MOESI(MOESI)) u_snoop (
        .cur  (snp_cur),
        .op   (s_op),
        .nxt  (snp_nxt),
        .resp (snp_resp)
    );

    coh_core_fsm u_core (
        .cur       (core_cur),
        .op        (c_op),
        .shared_in (shared_in),
        .nxt       (core_nxt),
        .req       (core_req),
        .wb        (core_wb)
    );

    always_comb begin
        for (int i = 0; i < LINES; i++) arr_d[i] = arr_q[i];
        if (snp_act)          arr_d[snp_idx]  = snp_nxt;
        if (c_op != CO_NONE)  arr_d[core_idx] = core_nxt;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < LINES; i++) begin
            arr_q[i] <= rst_n ? arr_d[i] : ST_I;
        end
    end

    assign bus_req    = core_req;
    assign shared_out = snp_resp.shared;
    assign supply_out = snp_resp.supply;
    assign flush_out  = snp_resp.flush;
    assign wb_out     = core_wb;
    assign cur_state  = arr_q[core_idx];

    a_r3_r10_silent_write: assert property (@(posedge clk) disable iff (!rst_n)
        (c_op == CO_WR && (core_cur == ST_E || core_cur == ST_M)) |-> bus_req == 2'd0);

    a_r5_write_ends_modified: assert property (@(posedge clk) disable iff (!rst_n)
        (c_op == CO_WR) |=> arr_q[$past(core_idx)] == ST_M);

    a_r9_evict_leaves_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (c_op == CO_EV) |=> arr_q[$past(core_idx)] == ST_I);

    a_r11_quiet_on_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_act && arr_q[snp_idx] == ST_I) |-> !(shared_out || supply_out || flush_out));

    a_r6_flush_only_supplied_read: assert property (@(posedge clk) disable iff (!rst_n)
        flush_out |-> (supply_out && s_op == BX_RD));

    a_r12_rdx_invalidates: assert property (@(posedge clk) disable iff (!rst_n)
        (s_op == BX_RDX && !(c_op != CO_NONE && core_idx == snp_idx))
        |=> arr_q[$past(snp_idx)] == ST_I);

    a_r8_owned_persists: assert property (@(posedge clk) disable iff (!rst_n)
        (s_op == BX_RD && arr_q[snp_idx] == ST_O && !(c_op != CO_NONE && core_idx == snp_idx))
        |=> arr_q[$past(snp_idx)] == ST_O);

endmodule

// File: tb/test_coh_line_ctrl.sv
module test_coh_line_ctrl;
    localparam int LINES = 8;
    localparam int IW    = $clog2(LINES);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    core_op = '0;
    logic [IW-1:0] core_idx = '0;
    logic          shared_in = 1'b0;
    logic [1:0]    snp_op = '0;
    logic [IW-1:0] snp_idx = '0;

    logic [1:0] breq [2];
    logic       shr  [2];
    logic       sup  [2];
    logic       fl   [2];
    logic       wb   [2];
    logic [2:0] cst  [2];

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int ref_st [2][LINES];   // [0] five-state policy, [1] four-state policy

    always #2 clk = ~clk;    // 250 MHz

    coh_line_ctrl #(.LINES(LINES), .MOESI(1'b1)) i_coh_line_ctrl (
        .clk(clk), .rst_n(rst_n), .core_op(core_op), .core_idx(core_idx),
        .shared_in(shared_in), .snp_op(snp_op), .snp_idx(snp_idx),
        .bus_req(breq[0]), .shared_out(shr[0]), .supply_out(sup[0]),
        .flush_out(fl[0]), .wb_out(wb[0]), .cur_state(cst[0]));

    coh_line_ctrl #(.LINES(LINES), .MOESI(1'b0)) i_coh_line_ctrl_mesi (
        .clk(clk), .rst_n(rst_n), .core_op(core_op), .core_idx(core_idx),
        .shared_in(shared_in), .snp_op(snp_op), .snp_idx(snp_idx),
        .bus_req(breq[1]), .shared_out(shr[1]), .supply_out(sup[1]),
        .flush_out(fl[1]), .wb_out(wb[1]), .cur_state(cst[1]));

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            report();
        end
    end

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // expected behaviour per policy, drawn from R1..R13
    task automatic step(int cop, int cidx, bit sh, int sop, int sidx);
        @(negedge clk);
        core_op = 2'(cop); core_idx = IW'(cidx); shared_in = sh;
        snp_op = 2'(sop); snp_idx = IW'(sidx);
        #1;
        for (int m = 0; m < 2; m++) begin
            int s = ref_st[m][sidx];
            int sn = s;
            int cc, cn;
            int e_req = 0;
            bit e_shr = 0, e_sup = 0, e_fl = 0, e_wb = 0;
            string stag = "";
            string ctag = "";
            if (sop == 1) begin
                case (s)
                    2: begin sn = 1; e_shr = 1; stag = "R2"; end
                    1: begin e_shr = 1; stag = "R2"; end
                    4: begin
                        e_shr = 1; e_sup = 1;
                        if (m == 0) begin sn = 3; stag = "R7"; end
                        else begin sn = 1; e_fl = 1; stag = "R6"; end
                    end
                    3: begin e_shr = 1; e_sup = 1; stag = "R8"; end
                    default: stag = "R11";
                endcase
            end else if (sop == 2) begin
                if (s != 0) begin
                    e_sup = (s == 4 || s == 3); sn = 0; stag = "R12";
                end else stag = "R11";
            end
            cc = (sop != 0 && sidx == cidx) ? sn : ref_st[m][cidx];
            cn = cc;
            case (cop)
                1: begin
                    if (cc == 0) begin
                        e_req = 1; cn = sh ? 1 : 2; ctag = sh ? "R2" : "R1";
                    end else ctag = "R1";
                end
                2: begin
                    if (cc == 0) begin e_req = 2; ctag = "R5"; end
                    else if (cc == 1 || cc == 3) begin e_req = 2; ctag = "R4"; end
                    else if (cc == 2) ctag = "R3";
                    else ctag = "R10";
                    cn = 4;
                end
                3: begin e_wb = (cc == 4 || cc == 3); cn = 0; ctag = "R9"; end
                default: ;
            endcase
            if (sop != 0 && cop != 0 && sidx == cidx) ctag = {ctag, " R13"};
            chk({stag, " ", ctag}, m ? "mesi cur_state" : "moesi cur_state",
                int'(cst[m]), ref_st[m][cidx]);
            chk({ctag, " "}, "bus_req", int'(breq[m]), e_req);
            chk({ctag, " "}, "wb_out", int'(wb[m]), int'(e_wb));
            chk({stag, " "}, "shared_out", int'(shr[m]), int'(e_shr));
            chk({stag, " "}, "supply_out", int'(sup[m]), int'(e_sup));
            chk({stag, " "}, "flush_out", int'(fl[m]), int'(e_fl));
            if (sop != 0) ref_st[m][sidx] = sn;
            if (cop != 0) ref_st[m][cidx] = cn;
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int m = 0; m < 2; m++)
            for (int i = 0; i < LINES; i++) ref_st[m][i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset: every line reads back as I
        for (int i = 0; i < LINES; i++) step(0, i, 0, 0, 0);

        // line 3: E, silent upgrade, dirty read by others, eviction
        step(1, 3, 0, 0, 0);   // R1 miss -> E
        step(1, 3, 0, 0, 0);   // R1 hit, no bus
        step(2, 3, 0, 0, 0);   // R3 E -> M silent
        step(2, 3, 0, 0, 0);   // R10 M write silent
        step(0, 0, 0, 1, 3);   // R6 / R7
        step(0, 0, 0, 1, 3);   // R8 owned keeps supplying
        step(3, 3, 0, 0, 0);   // R9 evict O (wb) / S (no wb)
        // line 5: shared install, upgrade, invalidate
        step(1, 5, 1, 0, 0);   // R2 miss with shared -> S
        step(2, 5, 0, 0, 0);   // R4 S -> M via BusRdX
        step(0, 0, 0, 2, 5);   // R12 RdX on M supplies, -> I
        step(0, 0, 0, 1, 5);   // R11 snoop on I
        step(0, 0, 0, 2, 5);   // R11 RdX on I
        // line 7: write miss
        step(2, 7, 0, 0, 0);   // R5
        step(0, 0, 0, 1, 7);
        step(2, 7, 0, 0, 0);   // R4 from O (or S)
        // line 2: E drops to S on foreign read, then same-cycle collision
        step(1, 2, 0, 0, 0);
        step(0, 0, 0, 1, 2);   // R2 E -> S
        step(2, 2, 0, 2, 2);   // R13 RdX first, then write miss from I
        step(1, 4, 0, 1, 4);   // R13 read miss with snoop on I line
        step(3, 2, 0, 1, 2);   // R13 snoop of M then evict

        for (int n = 0; n < 4000; n++) begin
            step(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                 bit'($urandom_range(0, 1)), int'($urandom_range(0, 2)),
                 int'($urandom_range(0, 3)));
        end
        @(negedge clk);
        report();
    end
endmodule